// File: doc/BRIEF.md
# Serial-Bus Memory Initialization Sequencer

This block brings a chain of memory devices out of reset and into a ready state. It does this by issuing a fixed, ordered script of control transactions to a serial transaction engine. After the start input is seen, it samples its configuration inputs. It then walks the script one transaction at a time, holding each request until the engine acknowledges it.

The script has four stages:
- A serial reset, followed by a mandatory guard-register write of zero.
- The clock-period write.
- Per-device serial and memory ID assignment, in order of distance along the chain.
- The exit-latency and read-latency writes, then a second reset.

The second reset is framed by a pair of test-register writes. Inside that frame, each device gets a set-reset command and then a clear-reset command.

The sequencer raises a done flag when the last transaction has been acknowledged. If an acknowledge does not arrive in time, it raises an error flag instead. The serial shifter, clock generation and later latency calibration sit outside this block.

Top module: `init_seq_top`

## Requirements
- R1: After reset, `req_valid_o`, `done_o` and `err_o` are low. No request appears until `start_i` is seen high at a clock edge.
- R2: The first request after start is a broadcast serial reset: kind 0, bcast 1, dev 0, addr 0, data 0. No register transaction comes before it.
- R3: The second request is a broadcast write (kind 1) of 0x0000 to the guard register at address 0x0A1.
- R4: The third request is a broadcast write of the sampled clock-period value, in 64 ps units, to address 0x0A2.
- R5: Device IDs are assigned for each device index d from 0 up to N-1, in increasing order. For each d there are two directed writes (bcast 0, dev d). The first puts data d into the serial-ID register at 0x0A3. The second puts the d-th 5-bit field of `cfg_mem_ids_i` (bits d*5+4..d*5) into the memory-ID register at 0x0A4.
- R6: Six broadcast writes follow, in this order:
  - power-down exit value to 0x0B0;
  - second power-down exit value to 0x0B1;
  - nap exit value to 0x0B2;
  - minimum read latency 0x0002 to 0x0B3;
  - minimum column delay 0x0001 to 0x0B4;
  - activate-to-column value to 0x0B5.
- R7: The closing stage runs in this order:
  - broadcast write 0x0004 to 0x0C0, then 0x0040 to 0x0C1;
  - for each device d in ascending order, a set-reset (kind 2) and then a clear-reset (kind 3), both directed to dev d with addr 0 and data 0;
  - broadcast write 0 to 0x0C1, then 0 to 0x0C0.
- R8: A device count of 0 is treated as 1. A count above MAX_DEV (32) is treated as MAX_DEV.
- R9: Only one transaction is outstanding at a time. While `req_valid_o` is high and `ack_i` is low, all request fields stay steady. The script advances only on an acknowledge sampled at a clock edge.
- R10: The configuration inputs are sampled at start. Changing them later in the run has no effect on the transaction stream.
- R11: If a request waits ACK_LIMIT (16) cycles without an acknowledge, `err_o` rises and `req_valid_o` drops. Both states hold until reset.
- R12: After the last acknowledge, `done_o` rises and `req_valid_o` drops; `done_o` holds until reset. `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clocks stable; begin the script |
| cfg_dev_count_i | input | 6 | Number of devices on the chain |
| cfg_period_i | input | 16 | Channel clock period in 64 ps units |
| cfg_pd_exit_i | input | 16 | Power-down exit timing value |
| cfg_pd_exit_a_i | input | 16 | Second power-down exit timing value |
| cfg_nap_exit_i | input | 16 | Nap exit timing value |
| cfg_act_col_i | input | 16 | Activate-to-column interval value |
| cfg_mem_ids_i | input | 160 | Memory ID per device, 5 bits each, device 0 in the low bits |
| ack_i | input | 1 | Transaction engine acknowledge |
| req_valid_o | output | 1 | Request pending |
| req_kind_o | output | 2 | 0 serial reset, 1 write, 2 set-reset, 3 clear-reset |
| req_bcast_o | output | 1 | Broadcast to all devices |
| req_dev_o | output | 5 | Target device for directed requests |
| req_addr_o | output | 12 | Register address |
| req_data_o | output | 16 | Write data |
| done_o | output | 1 | Script completed |
| err_o | output | 1 | Acknowledge timeout |

## Verification
The hardest case to reach from the ports is an acknowledge timeout in the middle of the script. By then the stream has already advanced, so the request has to go stale in a state other than the first one. The bench's responder therefore works from a budget of acknowledges. It grants exactly five, then stays silent, and the bench probes `err_o` on both sides of the 16-cycle window. The other hard-to-reach cases are the count clamps and a configuration change during a run. These come from a 45-device request, a zero-device request, and rewriting every configuration input right after start, all while the acknowledge gap cycles through 0 to 3 cycles.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

    localparam int ID_W   = 5;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        TK_SRST  = 2'd0,
        TK_WRITE = 2'd1,
        TK_SETR  = 2'd2,
        TK_CLRR  = 2'd3
    } txn_kind_e;

    typedef enum logic [4:0] {
        ST_IDLE, ST_SRST, ST_GUARD, ST_PERIOD, ST_SERID, ST_MEMID,
        ST_PDX, ST_PDXA, ST_NAPX, ST_RDLAT, ST_COLDLY, ST_ACTCOL,
        ST_TSTA_SET, ST_TSTB_SET, ST_SETR, ST_CLRR, ST_TSTB_CLR,
        ST_TSTA_CLR, ST_DONE, ST_ERR
    } step_e;

    localparam logic [ADDR_W-1:0] ADR_GUARD  = 12'h0A1;
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 12'h0A2;
    localparam logic [ADDR_W-1:0] ADR_SERID  = 12'h0A3;
    localparam logic [ADDR_W-1:0] ADR_MEMID  = 12'h0A4;
    localparam logic [ADDR_W-1:0] ADR_PDX    = 12'h0B0;
    localparam logic [ADDR_W-1:0] ADR_PDXA   = 12'h0B1;
    localparam logic [ADDR_W-1:0] ADR_NAPX   = 12'h0B2;
    localparam logic [ADDR_W-1:0] ADR_RDLAT  = 12'h0B3;
    localparam logic [ADDR_W-1:0] ADR_COLDLY = 12'h0B4;
    localparam logic [ADDR_W-1:0] ADR_ACTCOL = 12'h0B5;
    localparam logic [ADDR_W-1:0] ADR_TSTA   = 12'h0C0;
    localparam logic [ADDR_W-1:0] ADR_TSTB   = 12'h0C1;

    localparam logic [DATA_W-1:0] RD_LAT_MIN  = 16'h0002;
    localparam logic [DATA_W-1:0] COL_DLY_MIN = 16'h0001;
    localparam logic [DATA_W-1:0] TSTA_ARM    = 16'h0004;
    localparam logic [DATA_W-1:0] TSTB_ARM    = 16'h0040;

    typedef struct packed {
        txn_kind_e          kind;
        logic               bcast;
        logic [ID_W-1:0]    dev;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
    } txn_t;

    typedef struct packed {
        logic [ID_W-1:0]    last_dev;
        logic [DATA_W-1:0]  period;
        logic [DATA_W-1:0]  pdx;
        logic [DATA_W-1:0]  pdxa;
        logic [DATA_W-1:0]  napx;
        logic [DATA_W-1:0]  actcol;
    } cfg_t;

    // Index of the last device after clamping the count into 1..max_dev
    function automatic logic [ID_W-1:0] last_index(input int unsigned count,
                                                   input int unsigned max_dev);
        if (count == 0)
            return '0;
        if (count >= max_dev)
            return ID_W'(max_dev - 1);
        return ID_W'(count - 1);
    endfunction

    function automatic logic step_active(input step_e s);
        return !(s inside {ST_IDLE, ST_DONE, ST_ERR});
    endfunction

endpackage

// File: rtl/seq_cfg_latch.sv
module seq_cfg_latch
    import init_seq_pkg::*;
#(
    parameter int MAX_DEV = 32,
    parameter int CNT_W   = $clog2(MAX_DEV + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [CNT_W-1:0]          count_i,
    input  logic [DATA_W-1:0]         period_i,
    input  logic [DATA_W-1:0]         pdx_i,
    input  logic [DATA_W-1:0]         pdxa_i,
    input  logic [DATA_W-1:0]         napx_i,
    input  logic [DATA_W-1:0]         actcol_i,
    input  logic [MAX_DEV*ID_W-1:0]   ids_i,
    output cfg_t                      cfg_o,
    output logic [MAX_DEV*ID_W-1:0]   ids_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
            ids_o <= '0;
        end else if (load) begin
            cfg_o.last_dev <= last_index(int'(count_i), MAX_DEV);
            cfg_o.period   <= period_i;
            cfg_o.pdx      <= pdx_i;
            cfg_o.pdxa     <= pdxa_i;
            cfg_o.napx     <= napx_i;
            cfg_o.actcol   <= actcol_i;
            ids_o          <= ids_i;
        end
    end

endmodule

// File: rtl/seq_script.sv
module seq_script
    import init_seq_pkg::*;
#(
    parameter int MAX_DEV = 32,
    localparam int IDX_W  = $clog2(MAX_DEV)
) (
    input  step_e                     step_i,
    input  logic [ID_W-1:0]           dev_i,
    input  cfg_t                      cfg_i,
    input  logic [MAX_DEV*ID_W-1:0]   ids_i,
    output txn_t                      txn_o
);

    logic [ID_W-1:0] id_tbl [MAX_DEV];

    for (genvar g = 0; g < MAX_DEV; g++) begin : g_ids
        assign id_tbl[g] = ids_i[g*ID_W +: ID_W];
    end

    always_comb begin
        txn_o       = '0;
        txn_o.kind  = TK_WRITE;
        txn_o.bcast = 1'b1;
        unique case (step_i)
            ST_SRST:     txn_o.kind = TK_SRST;
            ST_GUARD:    txn_o.addr = ADR_GUARD;
            ST_PERIOD: begin
                txn_o.addr = ADR_PERIOD;
                txn_o.data = cfg_i.period;
            end
            ST_SERID: begin
                txn_o.bcast = 1'b0;
                txn_o.dev   = dev_i;
                txn_o.addr  = ADR_SERID;
                txn_o.data  = DATA_W'(dev_i);
            end
            ST_MEMID: begin
                txn_o.bcast = 1'b0;
                txn_o.dev   = dev_i;
                txn_o.addr  = ADR_MEMID;
                txn_o.data  = DATA_W'(id_tbl[dev_i[IDX_W-1:0]]);
            end
            ST_PDX: begin
                txn_o.addr = ADR_PDX;
                txn_o.data = cfg_i.pdx;
            end
            ST_PDXA: begin
                txn_o.addr = ADR_PDXA;
                txn_o.data = cfg_i.pdxa;
            end
            ST_NAPX: begin
                txn_o.addr = ADR_NAPX;
                txn_o.data = cfg_i.napx;
            end
            ST_RDLAT: begin
                txn_o.addr = ADR_RDLAT;
                txn_o.data = RD_LAT_MIN;
            end
            ST_COLDLY: begin
                txn_o.addr = ADR_COLDLY;
                txn_o.data = COL_DLY_MIN;
            end
            ST_ACTCOL: begin
                txn_o.addr = ADR_ACTCOL;
                txn_o.data = cfg_i.actcol;
            end
            ST_TSTA_SET: begin
                txn_o.addr = ADR_TSTA;
                txn_o.data = TSTA_ARM;
            end
            ST_TSTB_SET: begin
                txn_o.addr = ADR_TSTB;
                txn_o.data = TSTB_ARM;
            end
            ST_SETR: begin
                txn_o.kind  = TK_SETR;
                txn_o.bcast = 1'b0;
                txn_o.dev   = dev_i;
            end
            ST_CLRR: begin
                txn_o.kind  = TK_CLRR;
                txn_o.bcast = 1'b0;
                txn_o.dev   = dev_i;
            end
            ST_TSTB_CLR: txn_o.addr = ADR_TSTB;
            ST_TSTA_CLR: txn_o.addr = ADR_TSTA;
            default:     txn_o = '0;
        endcase
    end

endmodule

// File: rtl/seq_ack_timer.sv
module seq_ack_timer #(
    parameter int LIMIT = 16,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic waiting_i,
    output logic expired_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !waiting_i)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = waiting_i && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/init_seq_top.sv
module init_seq_top
    import init_seq_pkg::*;
#(
    parameter int MAX_DEV   = 32,
    parameter int ACK_LIMIT = 16,
    localparam int CNT_W    = $clog2(MAX_DEV + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [CNT_W-1:0]          cfg_dev_count_i,
    input  logic [DATA_W-1:0]         cfg_period_i,
    input  logic [DATA_W-1:0]         cfg_pd_exit_i,
    input  logic [DATA_W-1:0]         cfg_pd_exit_a_i,
    input  logic [DATA_W-1:0]         cfg_nap_exit_i,
    input  logic [DATA_W-1:0]         cfg_act_col_i,
    input  logic [MAX_DEV*ID_W-1:0]   cfg_mem_ids_i,
    input  logic                      ack_i,
    output logic                      req_valid_o,
    output logic [1:0]                req_kind_o,
    output logic                      req_bcast_o,
    output logic [ID_W-1:0]           req_dev_o,
    output logic [ADDR_W-1:0]         req_addr_o,
    output logic [DATA_W-1:0]         req_data_o,
    output logic                      done_o,
    output logic                      err_o
);

    step_e                   step_q, step_d;
    logic [ID_W-1:0]         dev_q, dev_d;
    cfg_t                    cfg;
    logic [MAX_DEV*ID_W-1:0] ids;
    txn_t                    txn;
    logic                    expired;
    logic                    load;

    assign load = (step_q == ST_IDLE) && start_i;

    seq_cfg_latch #(.MAX_DEV(MAX_DEV), .CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .count_i  (cfg_dev_count_i),
        .period_i (cfg_period_i),
        .pdx_i    (cfg_pd_exit_i),
        .pdxa_i   (cfg_pd_exit_a_i),
        .napx_i   (cfg_nap_exit_i),
        .actcol_i (cfg_act_col_i),
        .ids_i    (cfg_mem_ids_i),
        .cfg_o    (cfg),
        .ids_o    (ids)
    );

    seq_script #(.MAX_DEV(MAX_DEV)) u_script (
        .step_i (step_q),
        .dev_i  (dev_q),
        .cfg_i  (cfg),
        .ids_i  (ids),
        .txn_o  (txn)
    );

    seq_ack_timer #(.LIMIT(ACK_LIMIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .waiting_i (req_valid_o && !ack_i),
        .expired_o (expired)
    );

    // Successor of the current step once its acknowledge arrives
    always_comb begin
        step_d = step_q;
        dev_d  = dev_q;
        unique case (step_q)
            ST_SRST:     step_d = ST_GUARD;
            ST_GUARD:    step_d = ST_PERIOD;
            ST_PERIOD: begin
                step_d = ST_SERID;
                dev_d  = '0;
            end
            ST_SERID:    step_d = ST_MEMID;
            ST_MEMID: begin
                if (dev_q == cfg.last_dev) begin
                    step_d = ST_PDX;
                    dev_d  = '0;
                end else begin
                    step_d = ST_SERID;
                    dev_d  = dev_q + 1'b1;
                end
            end
            ST_PDX:      step_d = ST_PDXA;
            ST_PDXA:     step_d = ST_NAPX;
            ST_NAPX:     step_d = ST_RDLAT;
            ST_RDLAT:    step_d = ST_COLDLY;
            ST_COLDLY:   step_d = ST_ACTCOL;
            ST_ACTCOL:   step_d = ST_TSTA_SET;
            ST_TSTA_SET: step_d = ST_TSTB_SET;
            ST_TSTB_SET: begin
                step_d = ST_SETR;
                dev_d  = '0;
            end
            ST_SETR:     step_d = ST_CLRR;
            ST_CLRR: begin
                if (dev_q == cfg.last_dev) begin
                    step_d = ST_TSTB_CLR;
                    dev_d  = '0;
                end else begin
                    step_d = ST_SETR;
                    dev_d  = dev_q + 1'b1;
                end
            end
            ST_TSTB_CLR: step_d = ST_TSTA_CLR;
            ST_TSTA_CLR: step_d = ST_DONE;
            default:     step_d = step_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_IDLE;
            dev_q  <= '0;
        end else if (step_q == ST_IDLE) begin
            if (start_i) begin
                step_q <= ST_SRST;
                dev_q  <= '0;
            end
        end else if (step_active(step_q)) begin
            if (expired) begin
                step_q <= ST_ERR;
            end else if (ack_i) begin
                step_q <= step_d;
                dev_q  <= dev_d;
            end
        end
    end

    assign req_valid_o = step_active(step_q);
    assign req_kind_o  = txn.kind;
    assign req_bcast_o = txn.bcast;
    assign req_dev_o   = txn.dev;
    assign req_addr_o  = txn.addr;
    assign req_data_o  = txn.data;
    assign done_o      = (step_q == ST_DONE);
    assign err_o       = (step_q == ST_ERR);

endmodule

// File: rtl/init_seq_chk.sv
module init_seq_chk
    import init_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ack_i,
    input logic              req_valid_o,
    input logic [1:0]        req_kind_o,
    input logic              req_bcast_o,
    input logic [ID_W-1:0]   req_dev_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [DATA_W-1:0] req_data_o,
    input logic              done_o,
    input logic              err_o
);

    AST_FIRST_SRESET: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid_o) |-> (req_kind_o == 2'd0 && req_bcast_o)); // R2

    AST_GUARD_NEXT: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && ack_i && req_kind_o == 2'd0) |=>
        (req_valid_o && req_kind_o == 2'd1 && req_bcast_o &&
         req_addr_o == ADR_GUARD && req_data_o == '0)); // R3

    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !ack_i) |=>
        (err_o || (req_valid_o &&
         $stable({req_kind_o, req_bcast_o, req_dev_o, req_addr_o, req_data_o})))); // R9

    AST_SETR_CLRR: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && ack_i && req_kind_o == 2'd2) |=>
        (req_valid_o && req_kind_o == 2'd3 && $stable(req_dev_o))); // R7

    AST_ERR_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past(req_valid_o && !ack_i)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o |=> (err_o && !req_valid_o)); // R11

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && !req_valid_o)); // R12

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o)); // R12

endmodule

bind init_seq_top init_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack_i       (ack_i),
    .req_valid_o (req_valid_o),
    .req_kind_o  (req_kind_o),
    .req_bcast_o (req_bcast_o),
    .req_dev_o   (req_dev_o),
    .req_addr_o  (req_addr_o),
    .req_data_o  (req_data_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/tb_init_seq_top.sv
module tb_init_seq_top;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [5:0]    dev_count = '0;
    logic [15:0]   period = '0, pdx = '0, pdxa = '0, napx = '0, actcol = '0;
    logic [159:0]  ids = '0;
    logic          ack = 1'b0;
    logic          req_valid, req_bcast, done, err;
    logic [1:0]    req_kind;
    logic [4:0]    req_dev;
    logic [11:0]   req_addr;
    logic [15:0]   req_data;

    int checks = 0;
    int errors = 0;
    int ack_allow = 1000000;
    int ack_total = 0;
    int gap_cnt = 0;
    int gap_tgt = 0;
    bit prev_wait = 1'b0;
    logic [35:0] prev_fields = '0;

    logic [35:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    init_seq_top dut (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start),
        .cfg_dev_count_i (dev_count),
        .cfg_period_i    (period),
        .cfg_pd_exit_i   (pdx),
        .cfg_pd_exit_a_i (pdxa),
        .cfg_nap_exit_i  (napx),
        .cfg_act_col_i   (actcol),
        .cfg_mem_ids_i   (ids),
        .ack_i           (ack),
        .req_valid_o     (req_valid),
        .req_kind_o      (req_kind),
        .req_bcast_o     (req_bcast),
        .req_dev_o       (req_dev),
        .req_addr_o      (req_addr),
        .req_data_o      (req_data),
        .done_o          (done),
        .err_o           (err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [35:0] pk(input int k, input int b, input int d,
                                       input logic [11:0] a, input logic [15:0] v);
        return {2'(k), 1'(b), 5'(d), a, v};
    endfunction

    task automatic push(input logic [35:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // Expected script for a requested count, built from the requirements
    task automatic build(input int req_n);
        int n;
        string ct;
        n  = (req_n == 0) ? 1 : ((req_n > 32) ? 32 : req_n);
        ct = (n == req_n) ? "R5" : "R8";
        push(pk(0, 1, 0, 12'h000, 16'h0000), "R2");
        push(pk(1, 1, 0, 12'h0A1, 16'h0000), "R3");
        push(pk(1, 1, 0, 12'h0A2, period), "R4");
        for (int d = 0; d < n; d++) begin
            push(pk(1, 0, d, 12'h0A3, 16'(d)), ct);
            push(pk(1, 0, d, 12'h0A4, 16'(ids[d*5 +: 5])), ct);
        end
        push(pk(1, 1, 0, 12'h0B0, pdx), "R6");
        push(pk(1, 1, 0, 12'h0B1, pdxa), "R6");
        push(pk(1, 1, 0, 12'h0B2, napx), "R6");
        push(pk(1, 1, 0, 12'h0B3, 16'h0002), "R6");
        push(pk(1, 1, 0, 12'h0B4, 16'h0001), "R6");
        push(pk(1, 1, 0, 12'h0B5, actcol), "R6");
        push(pk(1, 1, 0, 12'h0C0, 16'h0004), "R7");
        push(pk(1, 1, 0, 12'h0C1, 16'h0040), "R7");
        for (int d = 0; d < n; d++) begin
            push(pk(2, 0, d, 12'h000, 16'h0000), ct == "R8" ? "R8" : "R7");
            push(pk(3, 0, d, 12'h000, 16'h0000), ct == "R8" ? "R8" : "R7");
        end
        push(pk(1, 1, 0, 12'h0C1, 16'h0000), "R7");
        push(pk(1, 1, 0, 12'h0C0, 16'h0000), "R7");
    endtask

    // Responder and scoreboard monitor, both on the falling edge
    always @(negedge clk) begin
        logic [35:0] obs;
        obs = {req_kind, req_bcast, req_dev, req_addr, req_data};
        if (rst) begin
            ack = 1'b0; gap_cnt = 0; gap_tgt = 0; ack_total = 0; prev_wait = 1'b0;
        end else begin
            if (prev_wait && req_valid)
                chk(obs == prev_fields, "R9", "fields moved while waiting", 64'(obs), 64'(prev_fields));
            if (req_valid && ack_total < ack_allow) begin
                if (gap_cnt >= gap_tgt) begin
                    ack = 1'b1; gap_cnt = 0; gap_tgt = (gap_tgt + 1) % 4;
                    ack_total++;
                    if (exp_q.size() == 0)
                        chk(1'b0, "R12", "request after end of script", 64'(obs), 64'(0));
                    else begin
                        logic [35:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(obs == e, t, "transaction", 64'(obs), 64'(e));
                    end
                end else begin
                    ack = 1'b0; gap_cnt++;
                end
            end else begin
                ack = 1'b0;
            end
            prev_wait   = req_valid && !ack;
            prev_fields = obs;
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        exp_q.delete();
        tag_q.delete();
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input int n, input int seed);
        dev_count = 6'(n);
        period = 16'(16'h0120 + seed);
        pdx    = 16'(16'h1100 + seed);
        pdxa   = 16'(16'h2200 + seed);
        napx   = 16'(16'h3300 + seed);
        actcol = 16'(16'h4400 + seed);
        for (int d = 0; d < 32; d++)
            ids[d*5 +: 5] = 5'((d * 7 + 3 + seed) % 32);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000 && !(done || err); i++)
            @(negedge clk);
    endtask

    task automatic full_run(input int n, input int seed, input bit disturb, input string tag);
        do_reset();
        ack_allow = 1000000;
        set_cfg(n, seed);
        build(n);
        pulse_start();
        if (disturb) begin
            set_cfg(5, seed + 9); // R10: late changes must not be seen
        end
        wait_end();
        chk(exp_q.size() == 0, tag, "script items left", 64'(exp_q.size()), 64'(0));
        chk(done == 1'b1, "R12", "done after script", 64'(done), 64'(1));
        chk(err == 1'b0, "R12", "err after good run", 64'(err), 64'(0));
        chk(req_valid == 1'b0, "R12", "valid after done", 64'(req_valid), 64'(0));
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R12", "done held", 64'(done), 64'(1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run hung actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: quiet after reset and without start
        chk(req_valid == 1'b0, "R1", "valid after reset", 64'(req_valid), 64'(0));
        chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'(0));
        chk(err == 1'b0, "R1", "err after reset", 64'(err), 64'(0));
        set_cfg(3, 0);
        repeat (6) @(negedge clk);
        chk(req_valid == 1'b0, "R1", "valid without start", 64'(req_valid), 64'(0));

        full_run(3, 1, 1'b1, "R10");   // R2..R7 with config rewritten after start
        full_run(1, 2, 1'b0, "R5");
        full_run(0, 3, 1'b0, "R8");    // zero count acts as one device
        full_run(45, 4, 1'b0, "R8");   // count above 32 clamps to 32

        // R11: acknowledge stops after five transactions
        do_reset();
        set_cfg(2, 5);
        build(2);
        ack_allow = 5;
        pulse_start();
        while (ack_total < 5) @(posedge clk);
        @(negedge clk);
        repeat (14) @(negedge clk);
        chk(err == 1'b0, "R11", "err before limit", 64'(err), 64'(0));
        chk(req_valid == 1'b1, "R11", "still waiting", 64'(req_valid), 64'(1));
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R11", "err after limit", 64'(err), 64'(1));
        chk(req_valid == 1'b0, "R11", "valid after timeout", 64'(req_valid), 64'(0));
        chk(done == 1'b0, "R12", "done with err", 64'(done), 64'(0));
        repeat (4) @(negedge clk);
        chk(err == 1'b1, "R11", "err held", 64'(err), 64'(1));
        ack_allow = 1000000;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule